// File: doc/BRIEF.md
# Terminal Address Latch and Parity Check

This block holds the 5-bit terminal address of a serial bus terminal, together with its parity bit, and reports whether the pair is valid. The address is taken from five address pins and a parity pin, or from the host data bus. A single latch pin selects one of three capture regimes:

- **Pin held low:** the stored address follows the pins.
- **Pin rises:** the pins are captured once on the rising edge.
- **Pin held high:** the host captures an address with a sequence of configuration writes.

Host capture happens on a write to configuration register 5, and only when two conditions already hold: an enhanced-mode bit is set in register 3, and a capture-enable bit is set in register 4. A source bit in register 6 selects where that capture reads from. When it is clear, the pins are sampled. When it is set, the write data supplies the address and parity.

A registered flag tells the command decoder whether the held address has odd parity. The decoder answers non-broadcast commands only while this flag is set.

Top module: `term_addr_unit`

## Requirements
- R1: After synchronous reset the outputs are address 0, parity 1 and valid 1. All configuration bits reset to 0.
- R2: While the synchronised latch pin is low, the stored address and parity load from the pins on every clock. They follow a pin change one clock later.
- R3: A rising edge on the latch pin is seen after two synchroniser flops, and the pins are captured at that edge. While the latch pin stays high, later pin changes leave the stored value unchanged.
- R4: While the latch pin is high, a write to index 5 captures the pins if three conditions hold: register 3 bit 15 is 1, register 4 bit 3 is 1, and register 6 bit 5 is 0.
- R5: Under the same conditions with register 6 bit 5 set to 1, the write captures data bits 5..1 as address bits 4..0 and data bit 0 as the parity bit.
- R6: A write to index 5 changes nothing while register 3 bit 15 or register 4 bit 3 is 0.
- R7: Only the named bit positions act as controls. Setting register 3 bit 14, or register 4 bit 2, does not enable host capture.
- R8: The valid output is 1 exactly when the five address bits and the parity bit contain an odd number of ones. It is registered, so it follows an address change by one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 3 | Configuration register index (3, 4, 5, 6 used) |
| cfg_wdata | input | 16 | Configuration write data |
| pin_addr | input | 5 | Address pins |
| pin_par | input | 1 | Parity pin |
| latch_pin | input | 1 | Asynchronous latch control pin |
| term_addr | output | 5 | Held terminal address |
| term_par | output | 1 | Held parity bit |
| addr_ok | output | 1 | Odd-parity valid flag |

## Verification
The assertions assume that the configuration write port and the address pins are synchronous to the clock. They also assume that a latch pin edge lasts long enough to pass the two synchroniser stages. The stimulus drives every input just after a falling clock edge. It holds the latch pin level for several cycles before any check, so each regime is settled when results are compared. Pin values are changed only where the requirement under test expects the change to be followed or ignored.

// File: rtl/tal_pkg.sv
package tal_pkg;
    localparam int ADDR_W   = 5;
    localparam int DATA_W   = 16;
    localparam int IDX_W    = 3;

    localparam logic [IDX_W-1:0] IDX_MODE   = 3'd3;
    localparam logic [IDX_W-1:0] IDX_ARM    = 3'd4;
    localparam logic [IDX_W-1:0] IDX_LOAD   = 3'd5;
    localparam logic [IDX_W-1:0] IDX_SRC    = 3'd6;

    localparam int BIT_ENH  = 15;
    localparam int BIT_ARM  = 3;
    localparam int BIT_SRC  = 5;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              par;
    } tad_t;

    typedef struct packed {
        logic enh;
        logic arm;
        logic sw_src;
    } ctl_t;

    localparam tad_t TAD_RESET = '{addr: '0, par: 1'b1};

    function automatic logic odd_ok(input tad_t t);
        return ^{t.addr, t.par};
    endfunction

    function automatic tad_t from_bus(input logic [DATA_W-1:0] d);
        tad_t t;
        t.addr = d[ADDR_W:1];
        t.par  = d[0];
        return t;
    endfunction
endpackage

// File: rtl/tal_cfg_bank.sv
module tal_cfg_bank
    import tal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output ctl_t              ctl,
    output logic              load_stb
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= '0;
        end else if (we) begin
            case (idx)
                IDX_MODE: ctl.enh    <= wdata[BIT_ENH];
                IDX_ARM:  ctl.arm    <= wdata[BIT_ARM];
                IDX_SRC:  ctl.sw_src <= wdata[BIT_SRC];
                default:  ;
            endcase
        end
    end

    assign load_stb = we && (idx == IDX_LOAD);
endmodule

// File: rtl/tal_pin_sync.sv
module tal_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic level,
    output logic rise
);
    logic [STAGES:0] chain;

    generate
        for (genvar i = 0; i <= STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= pin;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign level = chain[STAGES-1];
    assign rise  = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/tal_addr_latch.sv
module tal_addr_latch
    import tal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              level,
    input  logic              rise,
    input  ctl_t              ctl,
    input  logic              load_stb,
    input  logic [DATA_W-1:0] wdata,
    input  tad_t              pins,
    output tad_t              held,
    output logic              ok
);
    logic host_go;
    tad_t host_val;

    assign host_go  = level && !rise && load_stb && ctl.enh && ctl.arm;
    assign host_val = ctl.sw_src ? from_bus(wdata) : pins;

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= TAD_RESET;
        end else if (!level || rise) begin
            held <= pins;
        end else if (host_go) begin
            held <= host_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ok <= 1'b1;
        else     ok <= odd_ok(held);
    end

    p_follow_pins_r2: assert property (@(posedge clk) disable iff (rst)
        !level |=> held == $past(pins));

    p_edge_capture_r3: assert property (@(posedge clk) disable iff (rst)
        rise |=> held == $past(pins));

    p_hold_high_r3: assert property (@(posedge clk) disable iff (rst)
        (level && !rise && !load_stb) |=> $stable(held));

    p_bus_source_r5: assert property (@(posedge clk) disable iff (rst)
        (level && !rise && load_stb && ctl.enh && ctl.arm && ctl.sw_src)
        |=> held.addr == $past(wdata[ADDR_W:1]) && held.par == $past(wdata[0]));

    p_gate_closed_r6: assert property (@(posedge clk) disable iff (rst)
        (level && !rise && !(ctl.enh && ctl.arm)) |=> $stable(held));
endmodule

// File: rtl/term_addr_unit.sv
module term_addr_unit
    import tal_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic [ADDR_W-1:0] pin_addr,
    input  logic              pin_par,
    input  logic              latch_pin,
    output logic [ADDR_W-1:0] term_addr,
    output logic              term_par,
    output logic              addr_ok
);
    ctl_t ctl;
    logic load_stb, level, rise;
    tad_t pins, held;

    assign pins = '{addr: pin_addr, par: pin_par};

    tal_cfg_bank u_cfg (
        .clk(clk), .rst(rst), .we(cfg_we), .idx(cfg_idx), .wdata(cfg_wdata),
        .ctl(ctl), .load_stb(load_stb)
    );

    tal_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .pin(latch_pin), .level(level), .rise(rise)
    );

    tal_addr_latch u_latch (
        .clk(clk), .rst(rst), .level(level), .rise(rise), .ctl(ctl),
        .load_stb(load_stb), .wdata(cfg_wdata), .pins(pins),
        .held(held), .ok(addr_ok)
    );

    assign term_addr = held.addr;
    assign term_par  = held.par;

    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (term_addr == '0 && term_par && addr_ok));

    p_ok_tracks_parity_r8: assert property (@(posedge clk) disable iff (rst)
        ($stable(term_addr) && $stable(term_par)) |=> addr_ok == ^{$past(term_addr), $past(term_par)});
endmodule

// File: tb/tb_term_addr_unit.sv
module tb_term_addr_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [2:0]  cfg_idx;
    logic [15:0] cfg_wdata;
    logic [4:0]  pin_addr;
    logic        pin_par;
    logic        latch_pin;
    logic [4:0]  term_addr;
    logic        term_par;
    logic        addr_ok;

    typedef struct {
        string      req;
        logic [4:0] addr;
        logic       par;
        logic       ok;
    } exp_t;

    exp_t q[$];
    int   n_vec  = 0;
    int   n_bad  = 0;
    bit   done   = 1'b0;

    always #10 clk = ~clk;

    term_addr_unit dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .pin_addr(pin_addr), .pin_par(pin_par),
        .latch_pin(latch_pin), .term_addr(term_addr), .term_par(term_par),
        .addr_ok(addr_ok)
    );

    // monitor: pops expected items and compares at falling edges
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_vec++;
                if (term_addr !== e.addr || term_par !== e.par || addr_ok !== e.ok) begin
                    n_bad++;
                    $display("FAIL %s: got addr=%h par=%b ok=%b, expected addr=%h par=%b ok=%b",
                             e.req, term_addr, term_par, addr_ok, e.addr, e.par, e.ok);
                end
            end
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic expect_out(input string req, input logic [4:0] a, input logic p);
        exp_t e;
        e.req  = req;
        e.addr = a;
        e.par  = p;
        e.ok   = ^{a, p};
        q.push_back(e);
        idle(2);
    endtask

    task automatic cfg_write(input logic [2:0] idx, input logic [15:0] d);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_idx   = idx;
        cfg_wdata = d;
        @(negedge clk);
        cfg_we    = 1'b0;
        cfg_wdata = '0;
    endtask

    initial begin
        rst = 1'b1; cfg_we = 1'b0; cfg_idx = '0; cfg_wdata = '0;
        pin_addr = 5'h0; pin_par = 1'b0; latch_pin = 1'b0;
        idle(3);
        rst = 1'b0;
        // R1: reset value while latch pin low takes one clock to follow pins;
        // check before the first post-reset edge matters by holding rst through it.
        rst = 1'b1;
        @(negedge clk);
        expect_out("R1", 5'h00, 1'b1);
        rst = 1'b0;

        // R2: transparent following
        pin_addr = 5'h0A; pin_par = 1'b1;
        idle(3);
        expect_out("R2", 5'h0A, 1'b1);

        // R8: even parity gives invalid
        pin_addr = 5'h03; pin_par = 1'b0;
        idle(3);
        expect_out("R8", 5'h03, 1'b0);

        // R3: rising edge capture
        pin_addr = 5'h1F; pin_par = 1'b0;
        idle(2);
        latch_pin = 1'b1;
        idle(5);
        expect_out("R3", 5'h1F, 1'b0);
        pin_addr = 5'h04; pin_par = 1'b0;
        idle(3);
        expect_out("R3", 5'h1F, 1'b0);

        // R6: reset configuration blocks host capture
        cfg_write(3'd5, 16'h003F);
        idle(2);
        expect_out("R6", 5'h1F, 1'b0);

        // R7: neighbouring bits do not arm
        cfg_write(3'd3, 16'h4000);
        cfg_write(3'd4, 16'h0008);
        cfg_write(3'd5, 16'h0000);
        idle(2);
        expect_out("R7", 5'h1F, 1'b0);
        cfg_write(3'd3, 16'h8000);
        cfg_write(3'd4, 16'h0004);
        cfg_write(3'd5, 16'h0000);
        idle(2);
        expect_out("R7", 5'h1F, 1'b0);

        // R4: host capture from pins
        cfg_write(3'd4, 16'h0008);
        cfg_write(3'd5, 16'h003F);
        idle(2);
        expect_out("R4", 5'h04, 1'b0);

        // R5: host capture from data bus
        cfg_write(3'd6, 16'h0020);
        cfg_write(3'd5, 16'h002A);
        idle(2);
        expect_out("R5", 5'h15, 1'b0);
        cfg_write(3'd5, 16'h000C);
        idle(2);
        expect_out("R5", 5'h06, 1'b0);

        // R6: enhanced bit cleared
        cfg_write(3'd3, 16'h0000);
        cfg_write(3'd5, 16'h003F);
        idle(2);
        expect_out("R6", 5'h06, 1'b0);

        // R6: arm bit cleared
        cfg_write(3'd3, 16'h8000);
        cfg_write(3'd4, 16'h0000);
        cfg_write(3'd5, 16'h0021);
        idle(2);
        expect_out("R6", 5'h06, 1'b0);

        // R2: back to transparent
        latch_pin = 1'b0;
        idle(5);
        expect_out("R2", 5'h04, 1'b0);

        idle(3);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule